// File: doc/BRIEF.md
# Buffer Memory Priority Arbiter

This block decides which of four requesters owns a single shared buffer memory: a host processor port, a refresh engine and two block-transfer peripheral channels (A and B). It looks at the request lines only while the memory is idle. Once it has issued a grant, it holds that grant until the owner signals completion on `done`, so a burst is not interrupted by a requester of higher rank. The grant is registered and one-hot. It is released on the clock edge that samples `done`. The following cycle is spent arbitrating, and the new grant appears on the edge after that.

Two events can cut a channel burst short. Both do so through `force_eob`, a forced end-of-burst signal aimed at the channel being served. The first is a channel that cannot be stalled, that firmware has also chosen as the favoured channel, and whose FIFO is close to running dry. The second is a backlog of four pending refreshes. Refresh ticks are counted in a saturating queue. A refresh grant then covers as many refresh cycles as are pending, up to four, with one `done` pulse per cycle. In static RAM mode the refresh path is switched off completely. The block has no streaming data path: all pins are plain control and status signals.

Top module: `buf_arb_top`

## Requirements
- R1: A synchronous active-high `rst` clears `grant`, `force_eob` and the refresh queue. `grant` never has more than one bit set. Grant bit mapping is bit0 host, bit1 refresh, bit2 channel A, bit3 channel B.
- R2: While idle, the next grant follows a fixed order: host, then refresh (queue non-empty), then the favoured channel, then the other channel.
- R3: When exactly one channel is non-pausible (`pausible` bit 0 for A, bit 1 for B, value 0 = non-pausible), that channel is the favoured one whatever `fw_a_hi` says.
- R4: When both channels are pausible or both are non-pausible, `fw_a_hi`=1 favours channel A and `fw_a_hi`=0 favours channel B.
- R5: A grant stays unchanged until `done`, even if a higher-ranked request arrives. The edge that samples `done` clears the grant. The next grant appears one edge later.
- R6: When channel X is requesting, non-pausible, favoured, chosen by `fw_a_hi`, and its `almost_empty` bit is set, `force_eob` is raised for the other channel while that channel holds the grant (`force_eob` bit 0 = A, bit 1 = B). Without the firmware selection, nothing is forced.
- R7: Each `refresh_tick` adds one to the refresh queue. The queue saturates at 7. Each `done` during a refresh grant removes one.
- R8: When four or more refreshes are pending, the channel holding the grant sees `force_eob`. A refresh grant lasts min(pending, 4) `done` pulses.
- R9: While `sram_mode` is 1, ticks are not queued and refresh is never newly granted.
- R10: `force_eob` is only ever set for the channel currently granted, and is 0 while the host or refresh holds the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host processor access request |
| chan_req | input | 2 | Channel burst requests, bit 0 = A, bit 1 = B |
| pausible | input | 2 | 1 = channel can be stalled, per channel |
| fw_a_hi | input | 1 | Firmware priority select, 1 = A favoured |
| almost_empty | input | 2 | Channel FIFO nearly exhausted, per channel |
| sram_mode | input | 1 | Static RAM array, disables refresh |
| refresh_tick | input | 1 | One refresh interval has elapsed |
| done | input | 1 | Current owner completed its burst (or one refresh cycle) |
| grant | output | 4 | One-hot registered grant |
| force_eob | output | 2 | Forced end-of-burst to the served channel |

## Verification
A queue count that drifts shows up as a refresh grant whose length is wrong, or as a refresh grant that appears when none is pending. This becomes visible at the next refresh burst. It is also visible immediately at `force_eob` once the count crosses four. A mistaken choice of favoured channel shows in the grant two edges after a `done`. A missing hold shows as a grant change on the first edge after a competing request. The bench runs a behavioural model in step with the block and compares `grant` and `force_eob` on every cycle, so any such error is reported within one or two cycles of its cause.

// File: rtl/buf_arb_pkg.sv
package buf_arb_pkg;
  localparam int NSRC = 4;
  localparam int NCHAN = 2;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_RFSH = 2'd1,
    SRC_CHA  = 2'd2,
    SRC_CHB  = 2'd3
  } src_e;
endpackage

// File: rtl/buf_arb_refq.sv
module buf_arb_refq #(
  parameter int QW = 3,
  parameter int URG_LVL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          take,
  output logic [QW-1:0] q_cnt,
  output logic          pending,
  output logic          urgent
);
  localparam logic [QW-1:0] Q_MAX = {QW{1'b1}};
  localparam logic [QW-1:0] Q_URG = QW'(URG_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt <= '0;
    end else if (tick_en && !take && q_cnt != Q_MAX) begin
      q_cnt <= q_cnt + QW'(1);
    end else if (take && !tick_en && q_cnt != '0) begin
      q_cnt <= q_cnt - QW'(1);
    end
  end

  assign pending = (q_cnt != '0);
  assign urgent  = (q_cnt >= Q_URG);

  // R7: saturation holds the count at its ceiling
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (q_cnt == Q_MAX && tick_en && !take) |=> q_cnt == Q_MAX);
  // R7: a lone tick below the ceiling adds exactly one
  p_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (q_cnt != Q_MAX && tick_en && !take) |=> q_cnt == $past(q_cnt) + QW'(1));
  // R7: a lone completed refresh removes exactly one
  p_dec_r7: assert property (@(posedge clk) disable iff (rst)
    (q_cnt != '0 && take && !tick_en) |=> q_cnt == $past(q_cnt) - QW'(1));
endmodule

// File: rtl/buf_arb_chprio.sv
module buf_arb_chprio
  import buf_arb_pkg::*;
(
  input  logic [NCHAN-1:0] chan_req,
  input  logic [NCHAN-1:0] pausible,
  input  logic             fw_a_hi,
  input  logic [NCHAN-1:0] almost_empty,
  output logic             hi_sel,
  output logic [NCHAN-1:0] chan_urgent
);
  logic fw_pick;

  assign fw_pick = ~fw_a_hi;

  always_comb begin
    if (pausible[0] != pausible[1]) hi_sel = pausible[0];
    else                            hi_sel = fw_pick;
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_urg
    assign chan_urgent[c] = chan_req[c] & ~pausible[c] & almost_empty[c] &
                            (hi_sel == 1'(c)) & (fw_pick == 1'(c));
  end
endmodule

// File: rtl/buf_arb_pick.sv
module buf_arb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick[i]      = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
endmodule

// File: rtl/buf_arb_top.sv
module buf_arb_top
  import buf_arb_pkg::*;
#(
  parameter int QW = 3,
  parameter int URG_LVL = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_req,
  input  logic [1:0] chan_req,
  input  logic [1:0] pausible,
  input  logic       fw_a_hi,
  input  logic [1:0] almost_empty,
  input  logic       sram_mode,
  input  logic       refresh_tick,
  input  logic       done,
  output logic [3:0] grant,
  output logic [1:0] force_eob
);
  localparam logic [QW-1:0] BURST_CAP = QW'(URG_LVL);

  logic             hi_sel;
  logic [1:0]       chan_urgent;
  logic [QW-1:0]    q_cnt;
  logic             ref_pend;
  logic             ref_urg_raw;
  logic             ref_urgent;
  logic             ref_take;
  logic [QW-1:0]    burst_left;
  logic [NSRC-1:0]  ord_req;
  logic [NSRC-1:0]  ord_pick;
  logic [NSRC-1:0]  nxt_grant;
  logic             idle;

  buf_arb_refq #(.QW(QW), .URG_LVL(URG_LVL)) refq_i (
    .clk     (clk),
    .rst     (rst),
    .tick_en (refresh_tick & ~sram_mode),
    .take    (ref_take),
    .q_cnt   (q_cnt),
    .pending (ref_pend),
    .urgent  (ref_urg_raw)
  );

  buf_arb_chprio chprio_i (
    .chan_req     (chan_req),
    .pausible     (pausible),
    .fw_a_hi      (fw_a_hi),
    .almost_empty (almost_empty),
    .hi_sel       (hi_sel),
    .chan_urgent  (chan_urgent)
  );

  // rank order: host, refresh, favoured channel, other channel
  assign ord_req = {chan_req[~hi_sel], chan_req[hi_sel], ref_pend & ~sram_mode, host_req};

  buf_arb_pick #(.N(NSRC)) pick_i (
    .req  (ord_req),
    .pick (ord_pick)
  );

  assign nxt_grant[SRC_HOST] = ord_pick[0];
  assign nxt_grant[SRC_RFSH] = ord_pick[1];
  assign nxt_grant[SRC_CHA]  = hi_sel ? ord_pick[3] : ord_pick[2];
  assign nxt_grant[SRC_CHB]  = hi_sel ? ord_pick[2] : ord_pick[3];

  assign idle       = (grant == '0);
  assign ref_take   = grant[SRC_RFSH] & done;
  assign ref_urgent = ref_urg_raw & ~sram_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= '0;
      burst_left <= '0;
    end else if (idle) begin
      grant <= nxt_grant;
      if (nxt_grant[SRC_RFSH]) burst_left <= (q_cnt > BURST_CAP) ? BURST_CAP : q_cnt;
    end else if (done) begin
      if (grant[SRC_RFSH] && burst_left > QW'(1)) begin
        burst_left <= burst_left - QW'(1);
      end else begin
        grant      <= '0;
        burst_left <= '0;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_eob
    assign force_eob[c] = grant[2+c] & (ref_urgent | chan_urgent[1-c]);
  end

  // R1: never more than one owner
  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R1: reset empties the grant
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> grant == '0);
  // R2: an idle memory with a host request goes to the host
  p_host_first_r2: assert property (@(posedge clk) disable iff (rst)
    (idle && host_req) |=> grant == 4'b0001);
  // R5: no change without done
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!idle && !done) |=> grant == $past(grant));
  // R5: non-refresh owner releases on done
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (!idle && !grant[SRC_RFSH] && done) |=> grant == '0);
  // R9: static mode never starts a refresh grant
  p_sram_r9: assert property (@(posedge clk) disable iff (rst)
    (sram_mode && idle) |=> !grant[SRC_RFSH]);
  // R10: forced end only toward the served channel
  p_eob_served_r10: assert property (@(posedge clk) disable iff (rst)
    (force_eob & ~grant[3:2]) == 2'b00);
endmodule

// File: tb/buf_arb_top_tb_top.sv
module buf_arb_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_req = 1'b0;
  logic [1:0] chan_req = 2'b00;
  logic [1:0] pausible = 2'b11;
  logic       fw_a_hi = 1'b1;
  logic [1:0] almost_empty = 2'b00;
  logic       sram_mode = 1'b0;
  logic       refresh_tick = 1'b0;
  logic       done = 1'b0;
  logic [3:0] grant;
  logic [1:0] force_eob;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  buf_arb_top dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .chan_req(chan_req),
    .pausible(pausible), .fw_a_hi(fw_a_hi), .almost_empty(almost_empty),
    .sram_mode(sram_mode), .refresh_tick(refresh_tick), .done(done),
    .grant(grant), .force_eob(force_eob)
  );

  // behavioural reference: owner index (-1 none), queue, burst remainder
  int m_g = -1;
  int m_q = 0;
  int m_b = 0;
  bit m_seen = 1'b0;
  int t_inc, t_dec, t_nq, t_h;

  function automatic int fav_of();
    if (pausible[0] != pausible[1]) return pausible[0] ? 1 : 0;
    return fw_a_hi ? 0 : 1;
  endfunction

  function automatic logic [1:0] exp_eob();
    int h;
    bit urgc, urgr;
    logic [1:0] r;
    h = fav_of();
    urgc = chan_req[h] && !pausible[h] && almost_empty[h] && (h == (fw_a_hi ? 0 : 1));
    urgr = !sram_mode && m_q >= 4;
    for (int c = 0; c < 2; c++) r[c] = (m_g == 2 + c) && (urgr || (urgc && h != c));
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_g = -1; m_q = 0; m_b = 0;
    end else begin
      t_inc = (refresh_tick && !sram_mode) ? 1 : 0;
      t_dec = (m_g == 1 && done) ? 1 : 0;
      t_nq = m_q + t_inc - t_dec;
      if (t_nq > 7) t_nq = 7;
      if (m_g < 0) begin
        t_h = fav_of();
        if (host_req) m_g = 0;
        else if (!sram_mode && m_q > 0) begin m_g = 1; m_b = (m_q > 4) ? 4 : m_q; end
        else if (chan_req[t_h]) m_g = 2 + t_h;
        else if (chan_req[1 - t_h]) m_g = 3 - t_h;
      end else if (done) begin
        if (m_g == 1 && m_b > 1) m_b = m_b - 1;
        else m_g = -1;
      end
      m_q = t_nq;
    end
    m_seen = 1'b1;
  end

  always @(negedge clk) begin
    if (m_seen) begin
      logic [3:0] eg;
      eg = (m_g < 0) ? 4'b0000 : 4'(1 << m_g);
      n_chk++;
      if (grant !== eg) begin
        n_fail++;
        $display("FAIL R2/R5 model grant act=%b exp=%b t=%0t", grant, eg, $time);
      end
      n_chk++;
      if (force_eob !== exp_eob()) begin
        n_fail++;
        $display("FAIL R6/R8 model force_eob act=%b exp=%b t=%0t", force_eob, exp_eob(), $time);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk_g(logic [3:0] exp, string tag);
    n_chk++;
    if (grant !== exp) begin
      n_fail++;
      $display("FAIL %s grant act=%b exp=%b", tag, grant, exp);
    end
  endtask

  task automatic chk_e(logic [1:0] exp, string tag);
    n_chk++;
    if (force_eob !== exp) begin
      n_fail++;
      $display("FAIL %s force_eob act=%b exp=%b", tag, force_eob, exp);
    end
  endtask

  task automatic end_burst();
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    chk_g(4'b0000, "R1 reset");
    chk_e(2'b00, "R1 reset");
    rst = 1'b0;

    // R2: host beats channel A
    host_req = 1'b1; chan_req = 2'b01; step();
    chk_g(4'b0001, "R2 host first");
    host_req = 1'b0; end_burst();
    chk_g(4'b0000, "R5 idle after done");
    step(); chk_g(4'b0100, "R2 channel next");
    chan_req = 2'b00; end_burst(); step();

    // R4: peers follow firmware bit
    pausible = 2'b11; fw_a_hi = 1'b1; chan_req = 2'b11; step();
    chk_g(4'b0100, "R4 fw=1 A");
    end_burst(); fw_a_hi = 1'b0; step();
    chk_g(4'b1000, "R4 fw=0 B");
    chan_req = 2'b00; end_burst(); step();

    // R3: lone non-pausible channel wins
    pausible = 2'b10; fw_a_hi = 1'b0; chan_req = 2'b11; step();
    chk_g(4'b0100, "R3 A non-pausible");
    end_burst(); pausible = 2'b01; fw_a_hi = 1'b1; step();
    chk_g(4'b1000, "R3 B non-pausible");
    chan_req = 2'b00; end_burst(); step();

    // R5: no preemption
    pausible = 2'b11; fw_a_hi = 1'b1; chan_req = 2'b10; step();
    chk_g(4'b1000, "R5 B owner");
    host_req = 1'b1; chan_req = 2'b11; step(3);
    chk_g(4'b1000, "R5 held");
    end_burst(); chk_g(4'b0000, "R5 released");
    step(); chk_g(4'b0001, "R2 host after release");
    host_req = 1'b0; chan_req = 2'b00; end_burst(); step();
    chk_g(4'b0000, "R5 quiet");

    // R6: urgent favoured channel cuts the other burst
    pausible = 2'b10; fw_a_hi = 1'b1; chan_req = 2'b10; step();
    chk_g(4'b1000, "R6 B owner");
    chk_e(2'b00, "R10 no urgency");
    chan_req = 2'b11; almost_empty = 2'b01; step();
    chk_e(2'b10, "R6 forced on B");
    fw_a_hi = 1'b0; step();
    chk_e(2'b00, "R6 not firmware selected");
    fw_a_hi = 1'b1; step();
    end_burst(); chk_g(4'b0000, "R6 released");
    step(); chk_g(4'b0100, "R6 A wins");
    almost_empty = 2'b00; chan_req = 2'b00; end_burst(); step();

    // R8: refresh backlog forces end of burst, four-cycle refresh
    pausible = 2'b11; chan_req = 2'b01; step();
    chk_g(4'b0100, "R8 A owner");
    refresh_tick = 1'b1; step(3);
    chk_e(2'b00, "R8 three pending");
    step(); refresh_tick = 1'b0;
    chk_e(2'b01, "R8 four pending");
    chan_req = 2'b00; end_burst();
    step(); chk_g(4'b0010, "R8 refresh granted");
    done = 1'b1; step(3);
    chk_g(4'b0010, "R8 burst continues");
    step(); done = 1'b0;
    chk_g(4'b0000, "R8 burst of four");
    step(); chk_g(4'b0000, "R7 queue empty");

    // R7 / R10: saturation while host owns memory
    host_req = 1'b1; step();
    chk_g(4'b0001, "R7 host owner");
    refresh_tick = 1'b1; step(9); refresh_tick = 1'b0;
    chk_e(2'b00, "R10 host not forced");
    host_req = 1'b0; end_burst();
    step(); chk_g(4'b0010, "R7 refresh after host");
    done = 1'b1; step(4); done = 1'b0;
    chk_g(4'b0000, "R7 first burst done");
    step(); chk_g(4'b0010, "R7 three left");
    done = 1'b1; step(3); done = 1'b0;
    chk_g(4'b0000, "R7 second burst done");
    step(); chk_g(4'b0000, "R7 saturated at seven");

    // R9: static RAM mode ignores refresh
    sram_mode = 1'b1; refresh_tick = 1'b1; step(2); refresh_tick = 1'b0;
    step(); chk_g(4'b0000, "R9 no refresh in sram");
    sram_mode = 1'b0; step(2);
    chk_g(4'b0000, "R9 ticks not queued");

    step(2);
    summary();
  end
endmodule